// File: doc/BRIEF.md
# Addressed Slave Bus Gate

This block sits between a simple slave core and a shared serial peripheral bus. The master puts a small slave number on the bus address lines and raises a select strobe. Each slave compares that number with its own board address, which is a static strap input. When the strobe is high and the numbers agree, the slave is linked to the bus. While linked, the incoming serial clock and master-to-slave data pass through to the core. The core's slave-to-master data and the slave's request flag are driven onto the bus through output enables. While the slave is not linked, its bus outputs are released and the core sees fixed idle levels.

The block also handles service requests. A one-cycle local request pulse sets a held pending state. While that state is set, the block pulls the shared wired-low pending line low, through an output enable, and raises its own request flag. The master reads the flag by addressing each slave in turn. A one-cycle service-done pulse clears the pending state, which releases the pending line and drops the flag. The pending line is driven no matter which slave is addressed. The request flag reaches the bus only while this slave is linked.

Top module: `slave_bus_gate`

## Requirements
- R1: The link is active exactly when `bus_sel` is 1 and `bus_addr` equals `board_addr`. `core_linked` shows the link with no clock delay.
- R2: Each of the eight board addresses 0 to 7 links only to its own bus address. Every other address value leaves the link inactive.
- R3: While `bus_sel` is 0, the block ignores the value on `bus_addr`: `bus_miso_oe` and `bus_irq_oe` are 0.
- R4: While the link is active, `core_sclk` follows `bus_sclk` and `core_mosi` follows `bus_mosi`. `bus_miso` follows `core_miso` and `bus_miso_oe` is 1. All of these follow in the same cycle.
- R5: While the link is inactive, `core_sclk` and `core_mosi` are held at 0, and `bus_miso_oe` and `bus_irq_oe` are 0. This takes effect in the same cycle the link drops.
- R6: After a clock edge that samples `svc_req` = 1 with `svc_done` = 0, `bus_pend_pull` is 1 and `bus_irq` is 1.
- R7: After a clock edge that samples `svc_done` = 1, `bus_pend_pull` and `bus_irq` are 0. This holds even when `svc_req` is also 1 at that edge.
- R8: The pending state keeps its value through changes of `bus_sel` and `bus_addr`. `bus_irq_oe` is 1 only while the link is active.
- R9: After reset, `bus_pend_pull` and `bus_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pending state |
| rst_n | input | 1 | Active-low asynchronous reset |
| board_addr | input | 3 | Static local slave number |
| bus_sel | input | 1 | Select strobe from the master |
| bus_addr | input | 3 | Slave number from the master |
| bus_sclk | input | 1 | Serial clock from the bus |
| bus_mosi | input | 1 | Master-to-slave data from the bus |
| bus_miso | output | 1 | Slave-to-master data value |
| bus_miso_oe | output | 1 | Output enable for bus_miso |
| bus_irq | output | 1 | Per-slave request flag value |
| bus_irq_oe | output | 1 | Output enable for bus_irq |
| bus_pend_pull | output | 1 | Pulls the shared pending line low when 1 |
| core_sclk | output | 1 | Gated serial clock to the core |
| core_mosi | output | 1 | Gated master-to-slave data to the core |
| core_miso | input | 1 | Slave-to-master data from the core |
| core_linked | output | 1 | Link is active |
| svc_req | input | 1 | Single-cycle request pulse from the core |
| svc_done | input | 1 | Single-cycle service-complete pulse |

## Verification
The assertions assume that `board_addr` is static and that the bus inputs are settled when the clock edge samples them. They also assume that the request and done controls are single-cycle pulses from the same clock domain. The stimulus changes inputs only on the falling edge, keeps `board_addr` fixed within each test step, and drives the pulses for exactly one cycle. The stimulus also includes a cycle in which both pulses are high together, to exercise the case where done takes priority.

// File: rtl/slave_bus_pkg.sv
package slave_bus_pkg;
   typedef enum logic {
      PRI_DONE_WINS = 1'b0,
      PRI_REQ_WINS  = 1'b1
   } svc_pri_e;
endpackage

// File: rtl/addr_match.sv
module addr_match #(
   parameter int ADDR_W = 3
) (
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] local_addr,
   output logic              hit
);
   logic [ADDR_W-1:0] bit_eq;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      assign bit_eq[i] = ~(addr[i] ^ local_addr[i]);
   end

   assign hit = sel & (&bit_eq);
endmodule

// File: rtl/line_gate.sv
module line_gate #(
   parameter logic IDLE_CLK  = 1'b0,
   parameter logic IDLE_DATA = 1'b0
) (
   input  logic link,
   input  logic bus_clk_in,
   input  logic bus_din,
   input  logic core_dout,
   input  logic req_flag,
   output logic core_clk_out,
   output logic core_din,
   output logic bus_dout,
   output logic bus_dout_oe,
   output logic bus_req,
   output logic bus_req_oe
);
   assign core_clk_out = link ? bus_clk_in : IDLE_CLK;
   assign core_din     = link ? bus_din    : IDLE_DATA;
   assign bus_dout     = core_dout;
   assign bus_dout_oe  = link;
   assign bus_req      = req_flag;
   assign bus_req_oe   = link;
endmodule

// File: rtl/svc_request.sv
module svc_request
   import slave_bus_pkg::*;
#(
   parameter svc_pri_e PRIORITY = PRI_DONE_WINS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_pulse,
   input  logic clr_pulse,
   output logic pending
);
   logic nxt;

   if (PRIORITY == PRI_DONE_WINS) begin : g_done_wins
      always_comb begin
         if (clr_pulse)      nxt = 1'b0;
         else if (set_pulse) nxt = 1'b1;
         else                nxt = pending;
      end
   end else begin : g_req_wins
      always_comb begin
         if (set_pulse)      nxt = 1'b1;
         else if (clr_pulse) nxt = 1'b0;
         else                nxt = pending;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending <= 1'b0;
      else        pending <= nxt;
   end

   AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse && !clr_pulse |=> pending); // R6
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !set_pulse && !clr_pulse |=> $stable(pending)); // R8
endmodule

// File: rtl/slave_bus_gate.sv
module slave_bus_gate
   import slave_bus_pkg::*;
#(
   parameter int       ADDR_W    = 3,
   parameter logic     IDLE_CLK  = 1'b0,
   parameter logic     IDLE_DATA = 1'b0,
   parameter svc_pri_e PRIORITY  = PRI_DONE_WINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] board_addr,
   input  logic              bus_sel,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_sclk,
   input  logic              bus_mosi,
   output logic              bus_miso,
   output logic              bus_miso_oe,
   output logic              bus_irq,
   output logic              bus_irq_oe,
   output logic              bus_pend_pull,
   output logic              core_sclk,
   output logic              core_mosi,
   input  logic              core_miso,
   output logic              core_linked,
   input  logic              svc_req,
   input  logic              svc_done
);
   localparam int NUM_SLAVES = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_width
      $error("slave_bus_gate: ADDR_W must be within 1..8");
   end
   if (NUM_SLAVES < 2) begin : g_bad_count
      $error("slave_bus_gate: at least two slave numbers required");
   end

   logic link;
   logic pend_state;

   addr_match #(.ADDR_W(ADDR_W)) u_match (
      .sel        (bus_sel),
      .addr       (bus_addr),
      .local_addr (board_addr),
      .hit        (link)
   );

   svc_request #(.PRIORITY(PRIORITY)) u_svc (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_pulse (svc_req),
      .clr_pulse (svc_done),
      .pending   (pend_state)
   );

   line_gate #(.IDLE_CLK(IDLE_CLK), .IDLE_DATA(IDLE_DATA)) u_gate (
      .link         (link),
      .bus_clk_in   (bus_sclk),
      .bus_din      (bus_mosi),
      .core_dout    (core_miso),
      .req_flag     (pend_state),
      .core_clk_out (core_sclk),
      .core_din     (core_mosi),
      .bus_dout     (bus_miso),
      .bus_dout_oe  (bus_miso_oe),
      .bus_req      (bus_irq),
      .bus_req_oe   (bus_irq_oe)
   );

   assign bus_pend_pull = pend_state;
   assign core_linked   = link;

   AST_NO_DRIVE_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> !bus_miso_oe && !bus_irq_oe); // R3
   AST_ADDR_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
      bus_miso_oe |-> bus_sel && bus_addr == board_addr); // R1
   AST_IDLE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_irq_oe |-> core_sclk == IDLE_CLK && core_mosi == IDLE_DATA); // R5
   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      bus_miso_oe |-> core_sclk == bus_sclk && bus_miso == core_miso); // R4
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      svc_done && PRIORITY == PRI_DONE_WINS |=> !bus_pend_pull && !bus_irq); // R7
endmodule

// File: tb/slave_bus_gate_test.sv
module slave_bus_gate_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] board_addr = 3'd0;
   logic       bus_sel = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic       bus_sclk = 1'b0, bus_mosi = 1'b0, core_miso = 1'b0;
   logic       svc_req = 1'b0, svc_done = 1'b0;
   logic       bus_miso, bus_miso_oe, bus_irq, bus_irq_oe, bus_pend_pull;
   logic       core_sclk, core_mosi, core_linked;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   slave_bus_gate uut (
      .clk(clk), .rst_n(rst_n), .board_addr(board_addr),
      .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_sclk(bus_sclk),
      .bus_mosi(bus_mosi), .bus_miso(bus_miso), .bus_miso_oe(bus_miso_oe),
      .bus_irq(bus_irq), .bus_irq_oe(bus_irq_oe), .bus_pend_pull(bus_pend_pull),
      .core_sclk(core_sclk), .core_mosi(core_mosi), .core_miso(core_miso),
      .core_linked(core_linked), .svc_req(svc_req), .svc_done(svc_done)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   // {sel, addr[2:0], board[2:0], sclk, mosi, core_miso, exp_link}
   localparam logic [10:0] VEC [12] = '{
      {1'b1, 3'd0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1},
      {1'b1, 3'd5, 3'd5, 1'b0, 1'b1, 1'b0, 1'b1},
      {1'b1, 3'd7, 3'd7, 1'b1, 1'b1, 1'b1, 1'b1},
      {1'b1, 3'd3, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0},
      {1'b1, 3'd4, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0},
      {1'b0, 3'd6, 3'd6, 1'b1, 1'b1, 1'b1, 1'b0},
      {1'b0, 3'd1, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0},
      {1'b1, 3'd1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1},
      {1'b1, 3'd6, 3'd7, 1'b1, 1'b1, 1'b0, 1'b0},
      {1'b0, 3'd0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0},
      {1'b1, 3'd2, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1},
      {1'b1, 3'd0, 3'd4, 1'b0, 1'b1, 1'b1, 1'b0}
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic el;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9", "pend after reset", bus_pend_pull, 1'b0);
      chk("R9", "irq after reset", bus_irq, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R3 R4 R5: vector walk
      for (int i = 0; i < 12; i++) begin
         {bus_sel, bus_addr, board_addr, bus_sclk, bus_mosi, core_miso, el} = VEC[i];
         #2;
         chk("R1", "core_linked", core_linked, el);
         chk("R3", "miso_oe", bus_miso_oe, el);
         chk("R5", "irq_oe", bus_irq_oe, el);
         chk("R4", "core_sclk", core_sclk, el ? bus_sclk : 1'b0);
         chk("R4", "core_mosi", core_mosi, el ? bus_mosi : 1'b0);
         if (el) chk("R4", "bus_miso", bus_miso, core_miso);
         @(negedge clk);
      end

      // R2: exhaustive address sweep
      bus_sel = 1'b1;
      for (int b = 0; b < 8; b++) begin
         for (int a = 0; a < 8; a++) begin
            board_addr = 3'(b);
            bus_addr   = 3'(a);
            #1;
            chk("R2", "sweep link", core_linked, a == b);
         end
      end

      // R5: link drops in the same cycle
      board_addr = 3'd3; bus_addr = 3'd3; bus_sclk = 1'b1; bus_mosi = 1'b1;
      #1;
      chk("R5", "linked before drop", core_sclk, 1'b1);
      bus_sel = 1'b0;
      #1;
      chk("R5", "sclk idle after drop", core_sclk, 1'b0);
      chk("R5", "mosi idle after drop", core_mosi, 1'b0);
      @(negedge clk);

      // R6: request pulse
      svc_req = 1'b1;
      @(negedge clk);
      svc_req = 1'b0;
      chk("R6", "pend set", bus_pend_pull, 1'b1);
      chk("R6", "irq set", bus_irq, 1'b1);
      chk("R8", "irq_oe off unlinked", bus_irq_oe, 1'b0);

      // R8: persistence across addressing changes
      bus_sel = 1'b1; bus_addr = 3'd3;
      @(negedge clk);
      chk("R8", "irq_oe linked", bus_irq_oe, 1'b1);
      chk("R8", "pend held linked", bus_pend_pull, 1'b1);
      bus_addr = 3'd4;
      @(negedge clk);
      bus_sel = 1'b0;
      @(negedge clk);
      chk("R8", "pend held unlinked", bus_pend_pull, 1'b1);

      // R7: done clears
      svc_done = 1'b1;
      @(negedge clk);
      svc_done = 1'b0;
      chk("R7", "pend cleared", bus_pend_pull, 1'b0);
      chk("R7", "irq cleared", bus_irq, 1'b0);

      // R7: simultaneous req and done, with pending already set
      svc_req = 1'b1;
      @(negedge clk);
      svc_req = 1'b1; svc_done = 1'b1;
      @(negedge clk);
      svc_req = 1'b0; svc_done = 1'b0;
      chk("R7", "done wins pend", bus_pend_pull, 1'b0);
      chk("R7", "done wins irq", bus_irq, 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule